// File: doc/BRIEF.md
# Hot-Plug Slot Event Latch and Interrupt Aggregator

This block keeps one 32-bit status and control word for each hot-plug slot on a bridge. Each word carries three kinds of field. The live sense fields follow the slot's inputs directly. The event bits are sticky: each one is set by a change on a sense input and stays set until software clears it by writing 1 to it. The mask bits gate each event's interrupt contribution, and two further mask bits gate error reporting for the latch-change and connected-power-fault events.

The block reduces every slot's unmasked events to one pending bit per slot in a read-only locator word. Bit 0 of that word is the command-complete pending flag, and bit i+1 is the pending flag for slot i. A small controller word holds the global masks. One interrupt output and one error-report output are driven from these registers. Software reaches all of the registers through a simple single-cycle write port and a combinational read port.

Top module: `slot_evt_agg`

## Requirements
- R1: After reset, every slot word has control bits 5:0 = 6'h3F, mask bits 30:24 = 7'h7F and event bits 20:16 = 0. The controller word reads 3'b111. No event is latched on the first clock edge after reset, whatever the inputs are.
- R2: Bits 1:0 (slot state), 3:2 (power indicator) and 5:4 (attention indicator) can be read and written. The live fields read as follows: bit 6 is the inverse of `pwr_fault` (0 means a fault), bit 7 is `button`, bit 8 is `latch_open` (1 = open), bit 9 is `m66_cap` and bits 11:10 are the presence code (3 = empty).
- R3: On the clock edge after an input change, an event bit is set. Bit 16 is set by any change of the presence code, bit 18 by a rising edge of the button and bit 19 by any change of the latch. A rising edge of the fault input sets bit 20 when the slot state is 1 or 2, and sets bit 17 for any other state.
- R4: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. A new edge in the same cycle as a clear of the same bit leaves the bit set.
- R5: Bits 31, 23:21, 15 and 14:12 of a slot word always read 0, and writes to them are ignored.
- R6: Mask bits 28:24 (one for each of event bits 20:16) and error-report masks 29 (latch change) and 30 (connected power fault) can be read and written.
- R7: Locator bit 0 equals `cmd_pend`. Locator bit i+1 is the OR of slot i's event bits whose interrupt masks are clear. Writes to the locator are ignored.
- R8: `irq` = (any slot locator bit, or locator bit 0 with controller bit 2 clear) AND NOT controller bit 0. Setting bit 0 leaves the event bits unchanged.
- R9: `err_out` is the OR, over all slots, of (bit 19 with bit 29 clear) and (bit 20 with bit 30 clear). This OR is gated off by controller bit 1.
- R10: The address map is: 0 is the controller word (bits 2:0 read/write, all other bits 0), 1 is the locator, and 2+i is slot i. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Read data, combinational |
| cmd_pend | input | 1 | Command-complete pending from the command engine |
| prsnt | input | 2*NUM_SLOTS | Presence code, two bits per slot |
| latch_open | input | NUM_SLOTS | Retention latch sensor, 1 = open |
| button | input | NUM_SLOTS | Attention button level |
| pwr_fault | input | NUM_SLOTS | Power fault level, 1 = fault |
| m66_cap | input | NUM_SLOTS | Adapter 66 MHz capability |
| irq | output | 1 | Aggregated interrupt |
| err_out | output | 1 | Aggregated error report |

## Verification
The bench targets a clear and a fresh edge that land in the same cycle. A design that gives the clear priority would lose that event and read bit 18 as 0. It also checks the fault classification by slot state. If that choice were swapped, bits 17 and 20 would be exchanged and the error output would follow the wrong bit. The remaining directed cases cover the first edge after reset, the global masks and writes of all ones to the reserved bits. A design that latched events before it had a valid previous sample would show spurious events right after reset. One that stored the reserved bits would read them back as ones. The random phase then compares every register word and both outputs against a model in every cycle.

// File: rtl/slot_evt_pkg.sv
package slot_evt_pkg;
    localparam int WORD_W    = 32;
    localparam int CTL_W     = 6;
    localparam int NUM_EV    = 5;
    localparam int NUM_MSK   = 7;
    localparam int EV_LSB    = 16;
    localparam int MSK_LSB   = 24;

    // live field positions
    localparam int B_FLT     = 6;
    localparam int B_BTN     = 7;
    localparam int B_LAT     = 8;
    localparam int B_M66     = 9;
    localparam int B_PRS     = 10;

    // event indexes inside the event field
    localparam int E_PRS     = 0;
    localparam int E_IFLT    = 1;
    localparam int E_BTN     = 2;
    localparam int E_LAT     = 3;
    localparam int E_CFLT    = 4;

    // error-report mask indexes inside the mask field
    localparam int M_ERR_LAT  = 5;
    localparam int M_ERR_CFLT = 6;

    localparam logic [CTL_W-1:0]   CTL_RST = '1;
    localparam logic [NUM_MSK-1:0] MSK_RST = '1;
    localparam logic [1:0] ST_PWRONLY = 2'd1;
    localparam logic [1:0] ST_ENABLED = 2'd2;

    localparam int CTRL_ADDR = 0;
    localparam int LOC_ADDR  = 1;
    localparam int SLOT_BASE = 2;

    typedef struct packed {
        logic [CTL_W-1:0]   ctl;
        logic [NUM_EV-1:0]  ev;
        logic [NUM_MSK-1:0] msk;
        logic [1:0]         prs_s;
        logic               lat_s;
        logic               btn_s;
        logic               flt_s;
        logic               primed;
    } slot_st_t;

    typedef struct packed {
        logic cmd_m;
        logic err_m;
        logic irq_m;
    } ctrl_st_t;
endpackage

// File: rtl/slot_evt_latch.sv
module slot_evt_latch
    import slot_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hit,
    input  logic [CTL_W-1:0]     wr_ctl,
    input  logic [NUM_EV-1:0]    wr_clr,
    input  logic [NUM_MSK-1:0]   wr_msk,
    input  logic [1:0]           prs_in,
    input  logic                 lat_in,
    input  logic                 btn_in,
    input  logic                 flt_in,
    input  logic                 m66_in,
    output logic [WORD_W-1:0]    word_o
);
    slot_st_t s_d, s_q;
    logic [NUM_EV-1:0] set_v;
    logic [NUM_EV-1:0] clr_v;
    logic              connected;

    always_comb begin
        s_d       = s_q;
        set_v     = '0;
        connected = (s_q.ctl[1:0] == ST_PWRONLY) || (s_q.ctl[1:0] == ST_ENABLED);
        if (s_q.primed) begin
            set_v[E_PRS] = (prs_in != s_q.prs_s);
            set_v[E_BTN] = btn_in & ~s_q.btn_s;
            set_v[E_LAT] = lat_in ^ s_q.lat_s;
            if (flt_in && !s_q.flt_s) begin
                if (connected) set_v[E_CFLT] = 1'b1;
                else           set_v[E_IFLT] = 1'b1;
            end
        end
        clr_v  = wr_hit ? wr_clr : '0;
        // a fresh edge wins over a same-cycle clear
        s_d.ev = (s_q.ev & ~clr_v) | set_v;
        if (wr_hit) begin
            s_d.ctl = wr_ctl;
            s_d.msk = wr_msk;
        end
        s_d.prs_s  = prs_in;
        s_d.lat_s  = lat_in;
        s_d.btn_s  = btn_in;
        s_d.flt_s  = flt_in;
        s_d.primed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctl    <= CTL_RST;
            s_q.ev     <= '0;
            s_q.msk    <= MSK_RST;
            s_q.prs_s  <= '0;
            s_q.lat_s  <= 1'b0;
            s_q.btn_s  <= 1'b0;
            s_q.flt_s  <= 1'b0;
            s_q.primed <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        word_o                     = '0;
        word_o[CTL_W-1:0]          = s_q.ctl;
        word_o[B_FLT]              = ~flt_in;
        word_o[B_BTN]              = btn_in;
        word_o[B_LAT]              = lat_in;
        word_o[B_M66]              = m66_in;
        word_o[B_PRS +: 2]         = prs_in;
        word_o[EV_LSB +: NUM_EV]   = s_q.ev;
        word_o[MSK_LSB +: NUM_MSK] = s_q.msk;
    end
endmodule

// File: rtl/slot_evt_irq.sv
module slot_evt_irq
    import slot_evt_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0][NUM_EV-1:0]  ev_in,
    input  logic [NUM_SLOTS-1:0][NUM_MSK-1:0] msk_in,
    input  logic                              cmd_pend,
    input  ctrl_st_t                          ctl,
    output logic [NUM_SLOTS:0]                locator,
    output logic                              irq,
    output logic                              err_out
);
    logic [NUM_SLOTS-1:0] slot_pend;
    logic [NUM_SLOTS-1:0] slot_err;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign slot_pend[i] = |(ev_in[i] & ~msk_in[i][NUM_EV-1:0]);
        assign slot_err[i]  = (ev_in[i][E_LAT]  & ~msk_in[i][M_ERR_LAT]) |
                              (ev_in[i][E_CFLT] & ~msk_in[i][M_ERR_CFLT]);
    end

    assign locator = {slot_pend, cmd_pend};
    assign irq     = ((|slot_pend) | (cmd_pend & ~ctl.cmd_m)) & ~ctl.irq_m;
    assign err_out = (|slot_err) & ~ctl.err_m;
endmodule

// File: rtl/slot_evt_agg.sv
module slot_evt_agg
    import slot_evt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = $clog2(NUM_SLOTS + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [31:0]            wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [31:0]            rd_data,
    input  logic                   cmd_pend,
    input  logic [2*NUM_SLOTS-1:0] prsnt,
    input  logic [NUM_SLOTS-1:0]   latch_open,
    input  logic [NUM_SLOTS-1:0]   button,
    input  logic [NUM_SLOTS-1:0]   pwr_fault,
    input  logic [NUM_SLOTS-1:0]   m66_cap,
    output logic                   irq,
    output logic                   err_out
);
    localparam int CTL_BITS = $bits(ctrl_st_t);

    ctrl_st_t ctl_d, ctl_q;
    logic [NUM_SLOTS-1:0][WORD_W-1:0]  slot_word;
    logic [NUM_SLOTS-1:0][NUM_EV-1:0]  slot_ev;
    logic [NUM_SLOTS-1:0][NUM_MSK-1:0] slot_msk;
    logic [NUM_SLOTS:0]                locator;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_addr == ADDR_W'(SLOT_BASE + i));
        slot_evt_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (hit),
            .wr_ctl (wr_data[CTL_W-1:0]),
            .wr_clr (wr_data[EV_LSB +: NUM_EV]),
            .wr_msk (wr_data[MSK_LSB +: NUM_MSK]),
            .prs_in (prsnt[2*i +: 2]),
            .lat_in (latch_open[i]),
            .btn_in (button[i]),
            .flt_in (pwr_fault[i]),
            .m66_in (m66_cap[i]),
            .word_o (slot_word[i])
        );
        assign slot_ev[i]  = slot_word[i][EV_LSB +: NUM_EV];
        assign slot_msk[i] = slot_word[i][MSK_LSB +: NUM_MSK];
    end

    slot_evt_irq #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .ev_in    (slot_ev),
        .msk_in   (slot_msk),
        .cmd_pend (cmd_pend),
        .ctl      (ctl_q),
        .locator  (locator),
        .irq      (irq),
        .err_out  (err_out)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)))
            ctl_d = ctrl_st_t'(wr_data[CTL_BITS-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '1;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_ADDR))
            rd_data[CTL_BITS-1:0] = ctl_q;
        else if (rd_addr == ADDR_W'(LOC_ADDR))
            rd_data[NUM_SLOTS:0] = locator;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_addr == ADDR_W'(SLOT_BASE + i))
                rd_data = slot_word[i];
        end
    end
endmodule

// File: rtl/slot_evt_agg_chk.sv
module slot_evt_agg_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [ADDR_W-1:0]            rd_addr,
    input logic [31:0]                  rd_data,
    input logic [NUM_SLOTS-1:0]         button,
    input logic                         irq,
    input logic                         err_out,
    input logic [2:0]                   ctl_bits,
    input logic [NUM_SLOTS:0]           locator,
    input logic [NUM_SLOTS-1:0][31:0]   slot_word
);
    logic [1:0] ck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ck_q <= '0;
        else if (ck_q != 2'd3) ck_q <= ck_q + 2'd1;
    end

    // R8
    irq_gmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_bits[0] |-> !irq);

    // R9
    err_gmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_bits[1] |-> !err_out);

    // R5
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(rd_addr) >= 2) && (32'(rd_addr) < NUM_SLOTS + 2)) |->
        (rd_data[31] == 1'b0 && rd_data[23:21] == 3'b0 && rd_data[15:12] == 4'b0));

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        // R4
        loc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(locator[i+1]) |-> $past(wr_en && (wr_addr == ADDR_W'(i + 2))));

        // R3
        btn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((ck_q != 2'd0) && $rose(button[i])) |=> slot_word[i][18]);

        // R1
        no_early_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ck_q == 2'd1) |-> (slot_word[i][20:16] == 5'b0));
    end
endmodule

bind slot_evt_agg slot_evt_agg_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .button    (button),
    .irq       (irq),
    .err_out   (err_out),
    .ctl_bits  (ctl_q),
    .locator   (locator),
    .slot_word (slot_word)
);

// File: tb/slot_evt_agg_test.sv
module slot_evt_agg_test;
    localparam int NS = 4;
    localparam int AW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [31:0]     wr_data;
    logic [AW-1:0]   rd_addr;
    logic [31:0]     rd_data;
    logic            cmd_pend;
    logic [2*NS-1:0] prsnt;
    logic [NS-1:0]   latch_open, button, pwr_fault, m66_cap;
    logic            irq, err_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    slot_evt_agg #(.NUM_SLOTS(NS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_pend(cmd_pend), .prsnt(prsnt), .latch_open(latch_open),
        .button(button), .pwr_fault(pwr_fault), .m66_cap(m66_cap),
        .irq(irq), .err_out(err_out)
    );

    // reference model state
    logic [5:0] m_ctl [NS];
    logic [4:0] m_ev  [NS];
    logic [6:0] m_msk [NS];
    logic [1:0] p_prs [NS];
    logic       p_lat [NS];
    logic       p_btn [NS];
    logic       p_flt [NS];
    logic       m_primed;
    logic [2:0] m_cm;

    function automatic logic [31:0] exp_word(int i);
        logic [31:0] w = '0;
        w[5:0]   = m_ctl[i];
        w[6]     = ~pwr_fault[i];
        w[7]     = button[i];
        w[8]     = latch_open[i];
        w[9]     = m66_cap[i];
        w[11:10] = prsnt[2*i +: 2];
        w[20:16] = m_ev[i];
        w[30:24] = m_msk[i];
        return w;
    endfunction

    function automatic logic [NS:0] exp_loc();
        logic [NS:0] l = '0;
        l[0] = cmd_pend;
        for (int i = 0; i < NS; i++) l[i+1] = |(m_ev[i] & ~m_msk[i][4:0]);
        return l;
    endfunction

    function automatic logic exp_irq();
        logic [NS:0] l = exp_loc();
        return ((|l[NS:1]) | (l[0] & ~m_cm[2])) & ~m_cm[0];
    endfunction

    function automatic logic exp_err();
        logic e = 1'b0;
        for (int i = 0; i < NS; i++)
            e |= (m_ev[i][3] & ~m_msk[i][5]) | (m_ev[i][4] & ~m_msk[i][6]);
        return e & ~m_cm[1];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_ctl[i] = 6'h3F; m_ev[i] = '0; m_msk[i] = 7'h7F;
            p_prs[i] = '0; p_lat[i] = 0; p_btn[i] = 0; p_flt[i] = 0;
        end
        m_primed = 0;
        m_cm     = 3'b111;
    endtask

    task automatic model_update();
        for (int i = 0; i < NS; i++) begin
            logic [4:0] set_v = '0;
            logic [4:0] clr_v = '0;
            logic hit = wr_en && (int'(wr_addr) == i + 2);
            if (m_primed) begin
                set_v[0] = prsnt[2*i +: 2] != p_prs[i];
                set_v[2] = button[i] && !p_btn[i];
                set_v[3] = latch_open[i] != p_lat[i];
                if (pwr_fault[i] && !p_flt[i]) begin
                    if (m_ctl[i][1:0] == 2'd1 || m_ctl[i][1:0] == 2'd2) set_v[4] = 1;
                    else set_v[1] = 1;
                end
            end
            if (hit) clr_v = wr_data[20:16];
            m_ev[i] = (m_ev[i] & ~clr_v) | set_v;
            if (hit) begin
                m_ctl[i] = wr_data[5:0];
                m_msk[i] = wr_data[30:24];
            end
            p_prs[i] = prsnt[2*i +: 2];
            p_lat[i] = latch_open[i];
            p_btn[i] = button[i];
            p_flt[i] = pwr_fault[i];
        end
        if (wr_en && wr_addr == 0) m_cm = wr_data[2:0];
        m_primed = 1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        if (rd_addr == 0)
            chk("R10 controller word", rd_data, {29'b0, m_cm});
        else if (rd_addr == 1)
            chk("R7 locator word", rd_data, 32'(exp_loc()));
        else if (int'(rd_addr) < NS + 2)
            chk("R3 slot word", rd_data, exp_word(int'(rd_addr) - 2));
        else
            chk("R10 unmapped read", rd_data, 32'h0);
        chk("R8 irq", {31'b0, irq}, {31'b0, exp_irq()});
        chk("R9 err_out", {31'b0, err_out}, {31'b0, exp_err()});
    endtask

    task automatic cycle();
        model_update();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        wr_en = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1; wr_addr = AW'(a); wr_data = d;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = 3'd2;
        cmd_pend = 0; prsnt = '1; latch_open = '0; button = '0;
        pwr_fault = '0; m66_cap = 4'b0001;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 and R2: reset contents with live fields
        #1 chk("R1 slot0 reset word", rd_data, 32'h7F00_0E7F);
        rd_addr = 3'd3; #1 chk("R1 slot1 reset word", rd_data, 32'h7F00_0C7F);
        rd_addr = 3'd0; #1 chk("R1 controller reset", rd_data, 32'h7);

        // R1: first edge after reset latches nothing
        button[3] = 1; prsnt[1:0] = 2'b00; rd_addr = 3'd5;
        cycle();
        chk("R1 no event on first edge", 32'(rd_data[20:16]), 32'h0);
        cycle();

        // R3 / R4 on slot 0
        rd_addr = 3'd2;
        wr(2, 32'h0000_003F); cycle();
        button[0] = 1; cycle();
        chk("R3 button rise sets bit18", 32'(rd_data[18]), 32'h1);
        button[0] = 0; cycle();
        button[0] = 1; wr(2, 32'h0004_003F); cycle();
        chk("R4 edge beats clear", 32'(rd_data[18]), 32'h1);
        wr(2, 32'h0004_003F); cycle();
        chk("R4 write one clears", 32'(rd_data[18]), 32'h0);

        // R8 global mask
        button[0] = 0; cycle();
        button[0] = 1; wr(0, 32'h0); cycle();
        chk("R8 irq unmasked", {31'b0, irq}, 32'h1);
        wr(0, 32'h1); cycle();
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        chk("R8 latch kept under mask", 32'(rd_data[18]), 32'h1);

        // R9 error output
        latch_open[0] = 1; cycle();
        chk("R9 err on latch change", {31'b0, err_out}, 32'h1);
        wr(0, 32'h3); cycle();
        chk("R9 err gated", {31'b0, err_out}, 32'h0);

        // R5 / R6 reserved and masks
        rd_addr = 3'd3; wr(3, 32'hFFFF_FFFF); cycle();
        chk("R5 reserved bits zero", rd_data & 32'h80E0_F000, 32'h0);
        chk("R6 masks written", 32'(rd_data[30:24]), 32'h7F);
        chk("R2 control bits written", 32'(rd_data[5:0]), 32'h3F);

        // R3 fault classification on slot 2
        rd_addr = 3'd4; wr(4, 32'h7F00_0002); cycle();
        pwr_fault[2] = 1; cycle();
        chk("R3 connected fault bit20", 32'(rd_data[20:16]), 32'h10);
        chk("R2 fault bit active low", 32'(rd_data[6]), 32'h0);
        pwr_fault[2] = 0; wr(4, 32'h7F1F_0003); cycle();
        pwr_fault[2] = 1; cycle();
        chk("R3 isolated fault bit17", 32'(rd_data[20:16]), 32'h02);

        // R7 locator
        cmd_pend = 1; rd_addr = 3'd1; wr(0, 32'h0); cycle();
        chk("R7 locator cmd bit", 32'(rd_data[0]), 32'h1);
        chk("R7 locator slot0 bit", 32'(rd_data[1]), 32'h1);
        wr(1, 32'h0); cycle();
        chk("R7 locator write ignored", 32'(rd_data[1:0]), 32'h3);

        // R10 unmapped address
        rd_addr = 3'd7; #1 chk("R10 unmapped reads zero", rd_data, 32'h0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NS; i++) begin
                if ($urandom % 6 == 0) prsnt[2*i +: 2] = 2'($urandom);
                if ($urandom % 6 == 0) latch_open[i] = ~latch_open[i];
                if ($urandom % 5 == 0) button[i] = ~button[i];
                if ($urandom % 7 == 0) pwr_fault[i] = ~pwr_fault[i];
                if ($urandom % 9 == 0) m66_cap[i] = ~m66_cap[i];
            end
            cmd_pend = ($urandom % 3 == 0);
            if ($urandom % 4 == 0) wr(int'($urandom % 8), $urandom);
            rd_addr = AW'($urandom);
            cycle();
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule